// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block sits in front of the command path of an eight-bank memory. It watches row-activate strobes and makes sure that no more than four of them land inside any run of consecutive clocks shorter than a configured window. This keeps the instantaneous supply current within what the device can deliver. It drives a combinational allow signal, `act_ok`, for the current cycle. The scheduler is expected to issue an activate only while `act_ok` is high. An activate that arrives while `act_ok` is low is refused. The refused activate is not counted, and a one-cycle `act_viol` pulse reports it.

The window length comes from the row-to-row activate delay in nanoseconds and the clock period in nanoseconds. The block first converts the delay to whole clocks, rounding up. Only after that does it multiply the delay by four and add two clocks. The conversion is a repeated subtraction that runs once after reset or after a `cfg_load` strobe. Activates are never slowed by it. The accepted activate times are held as timestamps in a four-entry ring. When `eight_bank` is low the device has only four banks, and the limiter stands aside.

Top module: `act_window_limiter`

## Requirements
- R1: After a conversion ends (`cfg_busy` falls), `win_len` equals 4*ceil(`trrd_ns`/`tck_ns`)+2. The rounding is applied to the quotient before the multiply. For example, 7 ns at a 3 ns clock gives 14, and 0 ns gives 2.
- R2: A `tck_ns` of zero is treated as one nanosecond.
- R3: A synchronous reset (`rst_n` low) or a `cfg_load` strobe starts a conversion of the current `trrd_ns` and `tck_ns` and forgets all recorded activates. `cfg_busy` is high on the following cycle and stays high until the conversion ends. `act_viol` is low after reset.
- R4: With `eight_bank` high and no conversion running, `act_ok` is high exactly when fewer than four accepted activates fall in the last `win_len` clocks. An activate at clock t lies in that range when the current clock c satisfies c - t < `win_len`. Otherwise `act_ok` is low in the same cycle.
- R5: Once four activates are recorded, `act_ok` rises on exactly the clock that is `win_len` clocks after the oldest of them. With `win_len` = 10 and activates on every second clock, the fifth activate (clock 8) is refused and the one at clock 10 is accepted.
- R6: An activate presented while `eight_bank` is high and `act_ok` is low is not recorded. `act_viol` is high for one cycle on the clock after it.
- R7: With `eight_bank` low, `act_ok` is high, `act_viol` stays low, and activates are not recorded.
- R8: An activate accepted with `act_ok` high never raises `act_viol`. With `eight_bank` high, `act_ok` stays low while `cfg_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also starts a conversion |
| eight_bank | input | 1 | High: eight-bank device, limiter active |
| trrd_ns | input | NS_W | Row-to-row activate delay in ns |
| tck_ns | input | NS_W | Clock period in ns |
| cfg_load | input | 1 | Start a new conversion and clear the history |
| act | input | 1 | Activate strobe |
| act_ok | output | 1 | An activate this cycle is allowed |
| act_viol | output | 1 | Pulse: an activate was refused on the previous clock |
| cfg_busy | output | 1 | Conversion in progress |
| win_len | output | NS_W+4 | Window length in clocks |

## Verification
A wrong ring pointer or a stale timestamp shows at the ports as `act_ok` taking the wrong value on the very cycle an activate is tested. That means a refusal at a clock where the reference count of accepted activates is below four, or an acceptance one clock early or late at the window edge. A rounding fault in the conversion appears on `win_len` as soon as `cfg_busy` falls. The fault then shifts every later reopening of `act_ok` by a multiple of four clocks. A lost or extra refusal flag surfaces one clock later on `act_viol`.

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int NS_W  = 8,
  parameter int N_ACT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eight_bank,
  input  logic [NS_W-1:0] trrd_ns,
  input  logic [NS_W-1:0] tck_ns,
  input  logic            cfg_load,
  input  logic            act,
  output logic            act_ok,
  output logic            act_viol,
  output logic            cfg_busy,
  output logic [NS_W+3:0] win_len
);

  localparam int CW = NS_W + 4;
  localparam int PW = (N_ACT > 1) ? $clog2(N_ACT) : 1;

  logic [NS_W-1:0] rem, tck_r, quo;
  logic            busy;
  logic [CW-1:0]   now;
  logic [CW-1:0]   stamp [N_ACT];
  logic [N_ACT-1:0] valid;
  logic [PW-1:0]   wp;

  wire [NS_W-1:0] tck_fix    = (tck_ns == '0) ? NS_W'(1) : tck_ns;
  wire [CW-1:0]   oldest_age = now - stamp[wp];
  wire            slot_free  = !(&valid) || (oldest_age >= win_len);
  wire            take       = eight_bank && act && act_ok;
  wire [PW-1:0]   wp_next    = (wp == PW'(N_ACT - 1)) ? '0 : wp + PW'(1);

  assign win_len  = CW'(quo) * CW'(N_ACT) + CW'(2);
  assign cfg_busy = busy;
  assign act_ok   = !eight_bank || (!busy && slot_free);

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_load) begin
      busy  <= 1'b1;
      rem   <= trrd_ns;
      tck_r <= tck_fix;
      quo   <= '0;
      valid <= '0;
      wp    <= '0;
      for (int i = 0; i < N_ACT; i++) stamp[i] <= '0;
    end else begin
      if (busy) begin
        if (rem == '0) busy <= 1'b0;
        else begin
          rem <= (rem > tck_r) ? rem - tck_r : '0;
          quo <= quo + NS_W'(1);
        end
      end
      for (int i = 0; i < N_ACT; i++)
        if (valid[i] && (now - stamp[i]) >= win_len) valid[i] <= 1'b0;
      if (take) begin
        stamp[wp] <= now;
        valid[wp] <= 1'b1;
        wp        <= wp_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now      <= '0;
      act_viol <= 1'b0;
    end else begin
      now      <= now + CW'(1);
      act_viol <= eight_bank && act && !act_ok;
    end
  end

  assert_viol_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_viol |-> $past(act) && $past(eight_bank));

  assert_bypass_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!eight_bank) && $past(rst_n)) |-> !act_viol);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && eight_bank) |-> !act_ok);

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n || cfg_load)
    take |=> (wp != $past(wp)) && valid[$past(wp)]);

  assert_win_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_busy) |-> (win_len[1:0] == 2'b10));

  assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cfg_busy && (valid == '0));

endmodule

// File: tb/tb_act_window_limiter.sv
module tb_act_window_limiter;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, eight_bank = 1'b1, cfg_load = 1'b0, act = 1'b0;
  logic [7:0] trrd_ns = 8'd4, tck_ns = 8'd2;
  logic act_ok, act_viol, cfg_busy;
  logic [11:0] win_len;

  act_window_limiter dut (
    .clk(clk), .rst_n(rst_n), .eight_bank(eight_bank), .trrd_ns(trrd_ns),
    .tck_ns(tck_ns), .cfg_load(cfg_load), .act(act), .act_ok(act_ok),
    .act_viol(act_viol), .cfg_busy(cfg_busy), .win_len(win_len)
  );

  always #(PER/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, W = 10, p = 0;
  int m [4];
  bit exp_viol = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit good, input string tag, input int actual, input int expected);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, actual, expected);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) m[i] = -100000;
    p = 0;
    exp_viol = 1'b0;
  endtask

  task automatic load(input int tr, input int tc);
    int tcf, q;
    @(negedge clk);
    trrd_ns = 8'(tr); tck_ns = 8'(tc); cfg_load = 1'b1; act = 1'b0; eight_bank = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(cfg_busy == 1'b1, "R3 busy after load", cfg_busy, 1);
    chk(act_ok == 1'b0, "R8 blocked while busy", act_ok, 0);
    for (int k = 0; k < 300 && cfg_busy; k++) @(negedge clk);
    tcf = (tc == 0) ? 1 : tc;
    q = (tr + tcf - 1) / tcf;
    W = 4 * q + 2;
    chk(win_len == 12'(W), (tc == 0) ? "R2 window zero period" : "R1 window length", win_len, W);
    clear_model();
  endtask

  task automatic run(input int n, input int mode, input bit eb);
    bit a, ok_e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(act_viol == exp_viol, "R6 R8 violation pulse", act_viol, exp_viol);
      case (mode)
        0: a = (i % 2 == 0);
        1: a = 1'b1;
        2: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; a = lf[0] | lf[3]; end
        default: a = (i % 3 == 0);
      endcase
      eight_bank = eb; act = a;
      #1;
      ok_e = !eb || ((cyc - m[p]) >= W);
      chk(act_ok == ok_e, eb ? "R4 R5 allow" : "R7 bypass allow", act_ok, ok_e);
      exp_viol = eb && a && !ok_e;
      if (eb && a && ok_e) begin m[p] = cyc; p = (p + 1) % 4; end
    end
    @(negedge clk);
    chk(act_viol == exp_viol, "R6 R8 violation pulse", act_viol, exp_viol);
    act = 1'b0;
    exp_viol = 1'b0;
  endtask

  initial begin
    #(PER * 200000);
    errors++; checks++;
    $display("FAIL watchdog R4: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_busy == 1'b1, "R3 busy after reset", cfg_busy, 1);
    chk(act_viol == 1'b0, "R3 no pulse after reset", act_viol, 0);
    chk(act_ok == 1'b0, "R8 blocked after reset", act_ok, 0);
    for (int k = 0; k < 300 && cfg_busy; k++) @(negedge clk);
    chk(win_len == 12'd10, "R1 window after reset", win_len, 10);
    clear_model();

    run(14, 0, 1'b1);

    for (int tr = 0; tr <= 12; tr++)
      for (int tc = 0; tc <= 4; tc++)
        load(tr, tc);

    load(7, 3);
    run(60, 1, 1'b1);
    run(200, 2, 1'b1);
    load(3, 1);
    run(80, 3, 1'b1);
    run(40, 1, 1'b0);
    run(60, 1, 1'b1);
    load(0, 5);
    run(100, 2, 1'b1);
    load(4, 2);
    run(40, 0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule